// File: doc/BRIEF.md
# Three-Wire Configuration Port with Multi-Function Output

This block is a serial slave that lets an external controller load a bank of sixteen 12-bit configuration registers over three wires: a frame strobe, a data line and a shift clock. The serial pins are oversampled in the core clock domain. Bits enter a shift register on each rising shift clock. The frame is acted upon only when the strobe rises, so the frame length decides what kind of transfer it was. A long frame is a write, and only its newest 16 bits count. A frame of exactly four bits is a read request for one register.

The result of a read leaves the block on a multi-function output with its own output-enable. A 4-bit source selector in configuration register 3 controls that output. It can drive the serial readback, a fixed low or high level, or one of four internal status signals. It can also float the output. The serial interface only responds while a strap input is high. The whole register bank is also exported as a flat vector so that the rest of the chip can use the settings.

Top module: `serial_cfg_port`

## Requirements
- R1: A synchronous active-low reset clears every register to zero, except register 3, which resets to 12'h001 (selector = serial readback). The output is therefore enabled and low after reset.
- R2: Frame bits are taken MSB first on rising shift-clock edges. When the strobe rises after at least 16 clocks, bits [15:12] of the newest 16 bits name the register and bits [11:0] are written to it.
- R3: Leading bits beyond 16 in a write frame are discarded. Only the last 16 shifted bits decide the address and the data.
- R4: A frame of exactly 4 clocks is a read of the register named by those bits. No register changes. The 12 data bits appear on the output MSB first. The first bit is present after the strobe rises, and the output advances one bit on each falling shift-clock edge.
- R5: A frame with any other clock count below 16 (for example 6 or 15) changes no register.
- R6: While the mode strap is low, the serial pins have no effect on any register.
- R7: Selector (register 3 bits [3:0]) code 0 disables the output. Code 2 drives a low level and code 3 drives a high level, with the output enabled in both cases.
- R8: Selector codes 4, 5, 8 and 11 drive the oscillator, IF, lock and CCO inputs respectively onto the output, enabled. Code 1 drives the readback bit, which is 0 when no read is in progress.
- R9: All selector codes other than 0-5, 8 and 11 disable the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Strap that enables the serial interface when high |
| ser_en | input | 1 | Frame strobe; idles high, low while a frame is shifted |
| ser_dat | input | 1 | Serial data input |
| ser_clk | input | 1 | Serial shift clock |
| osc_in | input | 1 | Oscillator status signal, digital stand-in |
| if_in | input | 1 | IF signal, digital stand-in |
| lock_in | input | 1 | PLL lock status |
| cco_in | input | 1 | CCO signal, digital stand-in |
| mfo_out | output | 1 | Multi-function output data |
| mfo_oe | output | 1 | Output enable for mfo_out; low means high impedance |
| cfg_regs | output | 192 | All registers, register n at bits [12n+11:12n] |

## Verification
The bench builds the block with its default parameters: a 4-bit address, 12-bit data, two synchronizer stages and the selector in register 3. With these values every register address and all sixteen selector codes can be reached in a short run. A table of write frames is read back bit by bit through the output pin. Directed frames of 4, 6, 15, 16 and 20 clocks exercise the read, ignore and truncate decisions. The selector is swept over all codes with two opposite input patterns.

// File: rtl/cfg_port_pkg.sv
// Package: shared selector codes for the configuration port.
// Assumes a 4-bit output source selector.
package cfg_port_pkg;

    localparam int SEL_W = 4;

    typedef enum logic [SEL_W-1:0] {
        SRC_FLOAT = 4'd0,
        SRC_RDBK  = 4'd1,
        SRC_LOW   = 4'd2,
        SRC_HIGH  = 4'd3,
        SRC_OSC   = 4'd4,
        SRC_IF    = 4'd5,
        SRC_LOCK  = 4'd8,
        SRC_CCO   = 4'd11
    } mfo_src_e;

endpackage

// File: rtl/cfg_sync_edge.sv
// Module: cfg_sync_edge
// Brings W asynchronous pins into the core clock domain through a
// STAGES-deep synchronizer and reports level, rising and falling edges.
// Assumes every pin stays stable for several core clocks between changes.
module cfg_sync_edge #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] stg [STAGES];
    logic [W-1:0] prev;

    // Synchronizer chain plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
            prev <= '0;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
            prev <= stg[STAGES-1];
        end
    end

    // Edge flags derived from the settled level and its delayed copy
    always_comb begin
        lvl  = stg[STAGES-1];
        rise = lvl & ~prev;
        fall = ~lvl & prev;
    end
endmodule

// File: rtl/cfg_frame_rx.sv
// Module: cfg_frame_rx
// Shifts serial bits in on each shift-clock rise, counts clocks since the
// strobe fell, and classifies the frame when the strobe rises:
// exactly ADDR_W clocks is a read, FRAME_W or more is a write.
// Assumes edge inputs are single-cycle pulses that are already gated by the mode strap.
module cfg_frame_rx #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              en_rise,
    input  logic              en_fall,
    input  logic              sdi,
    output logic              wr_stb,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int FRAME_W = ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_RD  = CNT_W'(ADDR_W);

    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   cnt;

    // Shift register keeps only the newest FRAME_W bits
    always_ff @(posedge clk) begin
        if (!rst_n)         shreg <= '0;
        else if (sclk_rise) shreg <= {shreg[FRAME_W-2:0], sdi};
    end

    // Saturating clock counter, cleared when a frame begins
    always_ff @(posedge clk) begin
        if (!rst_n)                           cnt <= '0;
        else if (en_fall)                     cnt <= '0;
        else if (sclk_rise && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

    // Frame classification on the strobe's rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_stb  <= 1'b0;
            rd_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            rd_addr <= '0;
        end else begin
            wr_stb <= en_rise && (cnt == CNT_MAX);
            rd_stb <= en_rise && (cnt == CNT_RD);
            if (en_rise) begin
                wr_addr <= shreg[FRAME_W-1 -: ADDR_W];
                wr_data <= shreg[DATA_W-1:0];
                rd_addr <= shreg[ADDR_W-1:0];
            end
        end
    end
endmodule

// File: rtl/cfg_reg_bank.sv
// Module: cfg_reg_bank
// Holds 2**ADDR_W configuration registers of DATA_W bits each, with a
// reset value per register, one write port and one combinational read port.
// Assumes wr_en is a single-cycle pulse.
module cfg_reg_bank #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 12,
    parameter int SEL_REG     = 3,
    parameter int SEL_DEFAULT = 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    input  logic [ADDR_W-1:0]                 rd_addr,
    output logic [DATA_W-1:0]                 rd_data,
    output logic [(1<<ADDR_W)*DATA_W-1:0]     regs_flat
);
    localparam int NUM_REGS = 1 << ADDR_W;

    logic [DATA_W-1:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [DATA_W-1:0] RST_VAL =
            (i == SEL_REG) ? DATA_W'(SEL_DEFAULT) : '0;

        // One register: reset value or addressed write
        always_ff @(posedge clk) begin
            if (!rst_n)                                       regs[i] <= RST_VAL;
            else if (wr_en && wr_addr == ADDR_W'(i))          regs[i] <= wr_data;
        end

        assign regs_flat[i*DATA_W +: DATA_W] = regs[i];
    end

    assign rd_data = regs[rd_addr];
endmodule

// File: rtl/cfg_readback.sv
// Module: cfg_readback
// Loads a register word on a read strobe and presents it MSB first,
// shifting one bit on each falling shift-clock edge; zeros follow.
// Cleared when a new frame starts.
module cfg_readback #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              sclk_fall,
    input  logic              en_fall,
    output logic              bit_out
);
    logic [DATA_W-1:0] rb;

    // Readback shifter: load, clear on new frame, shift on falling clock
    always_ff @(posedge clk) begin
        if (!rst_n)         rb <= '0;
        else if (load)      rb <= load_data;
        else if (en_fall)   rb <= '0;
        else if (sclk_fall) rb <= {rb[DATA_W-2:0], 1'b0};
    end

    assign bit_out = rb[DATA_W-1];
endmodule

// File: rtl/cfg_out_mux.sv
// Module: cfg_out_mux
// Picks the multi-function output source from a 4-bit selector code.
// Unlisted codes float the output. The data bit is driven low whenever the enable is low.
module cfg_out_mux
    import cfg_port_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    input  logic             rdbk_bit,
    input  logic             osc_in,
    input  logic             if_in,
    input  logic             lock_in,
    input  logic             cco_in,
    output logic             mfo_out,
    output logic             mfo_oe
);
    // Source decode
    always_comb begin
        mfo_out = 1'b0;
        mfo_oe  = 1'b1;
        case (sel)
            SRC_RDBK: mfo_out = rdbk_bit;
            SRC_LOW:  mfo_out = 1'b0;
            SRC_HIGH: mfo_out = 1'b1;
            SRC_OSC:  mfo_out = osc_in;
            SRC_IF:   mfo_out = if_in;
            SRC_LOCK: mfo_out = lock_in;
            SRC_CCO:  mfo_out = cco_in;
            default:  mfo_oe  = 1'b0;
        endcase
    end
endmodule

// File: rtl/serial_cfg_port.sv
// Module: serial_cfg_port (top)
// Three-wire configuration slave with register bank and a selectable
// multi-function output. Serial pins are oversampled by clk. A frame is
// committed on the strobe's rising edge. Assumes the serial clock runs
// several times slower than clk and that mode_sel is a quasi-static strap.
module serial_cfg_port #(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_REG     = 3,
    parameter int SEL_LSB     = 0,
    parameter int SEL_DEFAULT = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          mode_sel,
    input  logic                          ser_en,
    input  logic                          ser_dat,
    input  logic                          ser_clk,
    input  logic                          osc_in,
    input  logic                          if_in,
    input  logic                          lock_in,
    input  logic                          cco_in,
    output logic                          mfo_out,
    output logic                          mfo_oe,
    output logic [(1<<ADDR_W)*DATA_W-1:0] cfg_regs
);
    import cfg_port_pkg::*;

    localparam int PIN_CLK = 0;
    localparam int PIN_DAT = 1;
    localparam int PIN_EN  = 2;

    logic [2:0]        pin_lvl, pin_rise, pin_fall;
    logic              sclk_rise, sclk_fall, en_rise, en_fall;
    logic              wr_stb, rd_stb;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [DATA_W-1:0] wr_data, rd_data;
    logic              rdbk_bit;
    logic [SEL_W-1:0]  sel_code;

    cfg_sync_edge #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ser_en, ser_dat, ser_clk}),
        .lvl  (pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    // Serial events only count while the mode strap is high
    always_comb begin
        sclk_rise = pin_rise[PIN_CLK] & mode_sel;
        sclk_fall = pin_fall[PIN_CLK] & mode_sel;
        en_rise   = pin_rise[PIN_EN]  & mode_sel;
        en_fall   = pin_fall[PIN_EN]  & mode_sel;
    end

    cfg_frame_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_rise(sclk_rise),
        .en_rise  (en_rise),
        .en_fall  (en_fall),
        .sdi      (pin_lvl[PIN_DAT]),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_stb   (rd_stb),
        .rd_addr  (rd_addr)
    );

    cfg_reg_bank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .SEL_REG(SEL_REG), .SEL_DEFAULT(SEL_DEFAULT)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_stb & mode_sel),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .regs_flat(cfg_regs)
    );

    cfg_readback #(.DATA_W(DATA_W)) u_rdbk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (rd_stb & mode_sel),
        .load_data(rd_data),
        .sclk_fall(sclk_fall),
        .en_fall  (en_fall),
        .bit_out  (rdbk_bit)
    );

    assign sel_code = cfg_regs[SEL_REG*DATA_W + SEL_LSB +: SEL_W];

    cfg_out_mux u_mux (
        .sel     (sel_code),
        .rdbk_bit(rdbk_bit),
        .osc_in  (osc_in),
        .if_in   (if_in),
        .lock_in (lock_in),
        .cco_in  (cco_in),
        .mfo_out (mfo_out),
        .mfo_oe  (mfo_oe)
    );
endmodule

// File: rtl/serial_cfg_port_chk.sv
// Module: serial_cfg_port_chk
// Checker bound into serial_cfg_port. Relates the frame strobes
// to the register bank contents over time.
module serial_cfg_port_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 12
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          mode_sel,
    input logic                          wr_stb,
    input logic                          rd_stb,
    input logic [ADDR_W-1:0]             wr_addr,
    input logic [DATA_W-1:0]             wr_data,
    input logic [(1<<ADDR_W)*DATA_W-1:0] cfg_regs
);
    // R2
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, rd_stb}));

    // R2
    write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && mode_sel) |=>
        cfg_regs[$past(wr_addr)*DATA_W +: DATA_W] == $past(wr_data));

    // R4
    read_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> $stable(cfg_regs));

    // R5
    no_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(cfg_regs));

    // R6
    mode_off_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sel |=> $stable(cfg_regs));
endmodule

bind serial_cfg_port serial_cfg_port_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_sel(mode_sel),
    .wr_stb  (wr_stb),
    .rd_stb  (rd_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cfg_regs(cfg_regs)
);

// File: tb/serial_cfg_port_test.sv
// Bench for serial_cfg_port: a table of write frames read back over the
// output pin, then directed checks for reset, frame lengths, mode strap
// and the output selector.
module serial_cfg_port_test;
    localparam int HALF = 8;   // core clocks per serial half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sel = 1'b1;
    logic ser_en = 1'b1;
    logic ser_dat = 1'b0;
    logic ser_clk = 1'b0;
    logic osc_in = 1'b0, if_in = 1'b0, lock_in = 1'b0, cco_in = 1'b0;
    logic mfo_out, mfo_oe;
    logic [191:0] cfg_regs;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    serial_cfg_port uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .ser_en(ser_en), .ser_dat(ser_dat), .ser_clk(ser_clk),
        .osc_in(osc_in), .if_in(if_in), .lock_in(lock_in), .cco_in(cco_in),
        .mfo_out(mfo_out), .mfo_oe(mfo_oe), .cfg_regs(cfg_regs)
    );

    localparam logic [15:0] WR_VEC [6] = '{
        16'h0123, 16'h1FFF, 16'h2A5A, 16'h7000, 16'hF800, 16'h9C3E
    };

    logic [191:0] model;

    task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_half();
        repeat (HALF) @(negedge clk);
    endtask

    // Shift n bits (MSB of the n first) and commit with the strobe
    task automatic send(input logic [31:0] bits, input int n);
        ser_en = 1'b0;
        wait_half();
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            wait_half();
            ser_clk = 1'b1;
            wait_half();
            ser_clk = 1'b0;
        end
        wait_half();
        ser_en = 1'b1;
        wait_half();
        wait_half();
    endtask

    // Read one register through the output pin
    task automatic read_reg(input logic [3:0] a, output logic [11:0] v);
        send({28'd0, a}, 4);
        for (int b = 11; b >= 0; b--) begin
            v[b] = mfo_out;
            ser_clk = 1'b1;
            wait_half();
            ser_clk = 1'b0;
            wait_half();
        end
    endtask

    function automatic logic [191:0] reset_image();
        logic [191:0] r = '0;
        r[3*12 +: 12] = 12'h001;
        return r;
    endfunction

    // Expected {oe, out} for a selector code and input pattern
    function automatic logic [1:0] mux_exp(input logic [3:0] c, input logic [3:0] p);
        case (c)
            4'd1:  return 2'b10;
            4'd2:  return 2'b10;
            4'd3:  return 2'b11;
            4'd4:  return {1'b1, p[0]};
            4'd5:  return {1'b1, p[1]};
            4'd8:  return {1'b1, p[2]};
            4'd11: return {1'b1, p[3]};
            default: return 2'b00;
        endcase
    endfunction

    initial begin
        logic [11:0] rv;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // R1: reset image and output enabled low
        model = reset_image();
        chk("R1 regs", cfg_regs, model);
        chk("R1 oe/out", {190'd0, mfo_oe, mfo_out}, {190'd0, 2'b10});

        // R2/R4: table of writes, each read back over the pin
        for (int k = 0; k < 6; k++) begin
            send({16'd0, WR_VEC[k]}, 16);
            model[WR_VEC[k][15:12]*12 +: 12] = WR_VEC[k][11:0];
            chk("R2 write", cfg_regs, model);
            read_reg(WR_VEC[k][15:12], rv);
            chk("R4 readback", {180'd0, rv}, {180'd0, WR_VEC[k][11:0]});
            chk("R4 read keeps regs", cfg_regs, model);
        end

        // R4: readback of reset-value selector register
        read_reg(4'd3, rv);
        chk("R4 readback reg3", {180'd0, rv}, {180'd0, 12'h001});

        // R3: 20-bit frame, leading 4 bits dropped
        send({12'd0, 4'hF, 4'h5, 12'hABC}, 20);
        model[5*12 +: 12] = 12'hABC;
        chk("R3 leading bits dropped", cfg_regs, model);

        // R5: 6 and 15 clock frames are ignored
        send({16'd0, 16'h6FFF} >> 10, 6);
        chk("R5 six clocks", cfg_regs, model);
        send({16'd0, 16'h6FFF}, 15);
        chk("R5 fifteen clocks", cfg_regs, model);

        // R6: mode strap low blocks a full write
        mode_sel = 1'b0;
        send({16'd0, 16'h6777}, 16);
        chk("R6 strap low", cfg_regs, model);
        mode_sel = 1'b1;
        repeat (4) @(negedge clk);

        // R7/R8/R9: sweep every selector code with two input patterns
        for (int c = 0; c < 16; c++) begin
            send({16'd0, 4'd3, 8'd0, 4'(c)}, 16);
            for (int p = 0; p < 2; p++) begin
                logic [3:0] pat;
                logic [1:0] e;
                pat = (p == 0) ? 4'b0101 : 4'b1010;
                {cco_in, lock_in, if_in, osc_in} = pat;
                repeat (2) @(negedge clk);
                e = mux_exp(4'(c), pat);
                if (c == 0 || c == 2 || c == 3)
                    chk($sformatf("R7 code %0d", c), {190'd0, mfo_oe, e[1] ? mfo_out : 1'b0}, {190'd0, e});
                else if (e[1])
                    chk($sformatf("R8 code %0d", c), {190'd0, mfo_oe, mfo_out}, {190'd0, e});
                else
                    chk($sformatf("R9 code %0d", c), {191'd0, mfo_oe}, {191'd0, 1'b0});
            end
        end

        // R8: readback resumes after the selector returns to code 1
        send({16'd0, 16'h3001}, 16);
        read_reg(4'd9, rv);
        chk("R8 readback after restore", {180'd0, rv}, {180'd0, 12'hC3E});

        // R1: reset mid-run restores defaults
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 re-reset", cfg_regs, reset_image());

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule